// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to 24 interrupt request lines to processors as interrupt messages. Each input has its own 64-bit routing entry. The entry sets the vector, the delivery mode, the destination mode, the input polarity, edge or level triggering, a mask and an 8-bit destination. A remote-IRR flag tracks level-triggered interrupts that are in service. When an input's effective request becomes active and the entry is not masked, the block holds a pending request for that input. It then presents one message at a time on a valid/ready output port, and the lowest-numbered pending input goes first.

Software never addresses a register directly. It first writes an 8-bit index into a select location at offset 0. It then reads or writes the chosen 32-bit register through a data window at offset 1. The ID, version and arbitration registers sit at the bottom of the index space. The routing entries follow, and each entry occupies two consecutive indices. An end-of-interrupt input returns a vector from the processor side. This clears the remote-IRR flag of the matching entry, so a level input that is still asserted is delivered again.

Top module: `irq_router`

## Requirements
- R1: Offset 0 (`reg_addr`=0) is an 8-bit select register that reads back in bits 7:0 with zeros above. Offset 1 is the window onto the register that the select value names. Reads are combinational.
- R2: Index 0x00 holds a writable 4-bit ID in bits 27:24. Index 0x01 always reads 0x00170011, which is the highest entry number (23) in bits 23:16 and the version code 0x11 in bits 7:0. Index 0x02 always reads zero. Writes to 0x01 and 0x02 have no effect.
- R3: Indices 0x03 to 0x0F and 0x40 to 0xFF read as zero, and writes to them change nothing.
- R4: Entry n uses indices 0x10+2n and 0x11+2n. The odd index holds the destination in bits 31:24, with zeros below. The even index holds the vector in 7:0, the delivery mode in 10:8, the destination mode in 11, the polarity in 13, remote IRR in 14, the trigger mode in 15 (1 = level) and the mask in 16. All other bits read as zero.
- R5: Bit 12 of an even index is the delivery status. It reads 1 while that entry's request is pending and not yet accepted, and 0 otherwise. Writes to it are ignored.
- R6: After reset, the select register reads 0 and the ID reads 8. Every entry reads zero, except its mask bit, which reads 1.
- R7: The effective request is the sampled input XOR the polarity bit, gated by the inverse of the mask. A masked input produces no message.
- R8: In edge mode, each inactive-to-active transition of the effective request raises exactly one request. The message becomes valid after the second rising clock edge following the input change.
- R9: In level mode, a request is raised while the effective request is active and remote IRR is clear. Raising it sets remote IRR, so an input that stays high produces no further messages.
- R10: An EOI clears remote IRR in the lowest-numbered entry whose vector equals the EOI vector, and in no other entry. If no entry matches, nothing changes. If that entry is level-triggered and its input is still active, a new message becomes valid one cycle after the EOI cycle.
- R11: While `pwr_good` is low, no new request is raised. Input sampling and edge tracking continue, so an edge that occurs while power is low is never delivered.
- R12: Among the pending inputs, the lowest-numbered one drives the message port. `msg_valid` stays high until `msg_ready` is sampled high. Acceptance removes only that input's request.
- R13: A message carries the entry's destination mode, delivery mode, trigger mode, vector and destination, with `msg_level` fixed at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = select register, 1 = data window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pwr_good | input | 1 | Allows new requests when high |
| irq_in | input | 24 | Raw interrupt inputs |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_dest_mode | output | 1 | Destination mode of the message |
| msg_deliv | output | 3 | Delivery mode of the message |
| msg_level | output | 1 | Level bit, always 1 |
| msg_trig | output | 1 | Trigger mode of the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination of the message |

## Verification
A corrupted pending or remote-IRR bit shows up at the ports within one or two cycles. It appears either as a message that never arrives, as a duplicate message, or as a wrong delivery-status or remote-IRR bit in the entry word read through the window. A wrong edge-tracking register shows up at the next input transition as a missing or extra message. A decode error in the select/window path shows up on the first read of the affected index. The bench therefore compares every window read against a software model, and it checks the message port in the exact cycle that R8 and R10 predict.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // One routing entry. The layout is packed for storage; the software view
  // is built separately in the register file.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;   // 1 = level
    logic       rirr;
    logic       pol;    // 1 = active low
    logic       dmode;
    logic [2:0] deliv;
    logic [7:0] vec;
  } route_ent_t;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL  = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h11;
  localparam logic [3:0] ID_RST   = 4'h8;
  localparam logic [3:0] ARB_VAL  = 4'h0;

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/rr_pick.sv
// Lowest-index-first selection: one-hot grant plus its binary index.
module rr_pick #(
  parameter int W  = 24,
  parameter int IW = 5
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  oh,
  output logic [IW-1:0] idx,
  output logic          any
);

  assign oh  = req & (~req + W'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (oh[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/rr_regfile.sv
module rr_regfile
  import irq_route_pkg::*;
#(
  parameter int NUM_IN = 24,
  parameter int ENT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_en,
  input  logic                    addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_IN-1:0]       pend,
  input  logic [NUM_IN-1:0]       rirr_set,
  input  logic [NUM_IN-1:0]       rirr_clr,
  output route_ent_t [NUM_IN-1:0] ents_o
);

  localparam logic [8:0] TBL_END = 9'(16 + 2 * NUM_IN);

  logic [7:0] sel_q, sel_d;
  logic       sel_we;
  logic [3:0] id_q, id_d;
  logic       id_we;
  route_ent_t [NUM_IN-1:0] ent_q, ent_d;
  logic [NUM_IN-1:0]       ent_we;

  logic             tbl_hit;
  logic [7:0]       tbl_off;
  logic [ENT_W-1:0] tbl_idx;
  logic             win_wr;
  logic [31:0]      win;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[23:17], wdata[12]};

  // Window decode
  assign tbl_hit = (sel_q >= IDX_TBL) && ({1'b0, sel_q} < TBL_END);
  assign tbl_off = sel_q - IDX_TBL;
  assign tbl_idx = ENT_W'(tbl_off >> 1);
  assign win_wr  = wr_en & addr;

  assign sel_we = wr_en & ~addr;
  assign id_we  = win_wr & (sel_q == IDX_ID);

  // Next state
  always_comb begin
    sel_d = wdata[7:0];
    id_d  = wdata[27:24];
    ent_d = ent_q;
    for (int i = 0; i < NUM_IN; i++) begin
      if (win_wr && tbl_hit && (tbl_idx == ENT_W'(i))) begin
        if (sel_q[0]) begin
          ent_d[i].dest = wdata[31:24];
        end else begin
          ent_d[i].vec   = wdata[7:0];
          ent_d[i].deliv = wdata[10:8];
          ent_d[i].dmode = wdata[11];
          ent_d[i].pol   = wdata[13];
          ent_d[i].rirr  = wdata[14];
          ent_d[i].trig  = wdata[15];
          ent_d[i].mask  = wdata[16];
        end
      end
      // hardware updates take effect after the software write
      if (rirr_clr[i]) ent_d[i].rirr = 1'b0;
      if (rirr_set[i]) ent_d[i].rirr = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      ent_we[i] = (win_wr & tbl_hit & (tbl_idx == ENT_W'(i)))
                | rirr_set[i] | rirr_clr[i];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= ID_RST;
    end else begin
      if (sel_we) sel_q <= sel_d;
      if (id_we)  id_q  <= id_d;
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g]      <= '0;
        ent_q[g].mask <= 1'b1;
      end else if (ent_we[g]) begin
        ent_q[g] <= ent_d[g];
      end
    end
  end

  // Read path
  always_comb begin
    win = '0;
    if (sel_q == IDX_ID) begin
      win[27:24] = id_q;
    end else if (sel_q == IDX_VER) begin
      win[23:16] = 8'(NUM_IN - 1);
      win[7:0]   = VER_CODE;
    end else if (sel_q == IDX_ARB) begin
      win[27:24] = ARB_VAL;
    end else if (tbl_hit) begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (tbl_idx == ENT_W'(i)) begin
          if (sel_q[0]) begin
            win[31:24] = ent_q[i].dest;
          end else begin
            win[16]   = ent_q[i].mask;
            win[15]   = ent_q[i].trig;
            win[14]   = ent_q[i].rirr;
            win[13]   = ent_q[i].pol;
            win[12]   = pend[i];
            win[11]   = ent_q[i].dmode;
            win[10:8] = ent_q[i].deliv;
            win[7:0]  = ent_q[i].vec;
          end
        end
      end
    end
  end

  assign rdata  = addr ? win : {24'h0, sel_q};
  assign ents_o = ent_q;

endmodule

// File: rtl/rr_request.sv
module rr_request #(
  parameter int NUM_IN = 24,
  parameter int ENT_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   pwr_good,
  input  logic [NUM_IN-1:0]      irq_in,
  input  logic [NUM_IN-1:0]      pol,
  input  logic [NUM_IN-1:0]      mask,
  input  logic [NUM_IN-1:0]      trig,
  input  logic [NUM_IN-1:0]      rirr,
  input  logic [NUM_IN-1:0][7:0] vec,
  input  logic                   eoi_valid,
  input  logic [7:0]             eoi_vector,
  input  logic                   accept,
  output logic [NUM_IN-1:0]      pend_o,
  output logic [NUM_IN-1:0]      rirr_set,
  output logic [NUM_IN-1:0]      rirr_clr,
  output logic                   gnt_any,
  output logic [ENT_W-1:0]       gnt_idx
);

  logic [NUM_IN-1:0] raw_q, raw_d;
  logic [NUM_IN-1:0] eff, eff_q;
  logic [NUM_IN-1:0] pend_q, pend_d;
  logic [NUM_IN-1:0] edge_req, lvl_req;
  logic [NUM_IN-1:0] eoi_hit, eoi_first;
  logic [NUM_IN-1:0] gnt_oh, take;

  assign raw_d = irq_in;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    assign eff[g]      = (raw_q[g] ^ pol[g]) & ~mask[g];
    assign edge_req[g] = pwr_good & ~trig[g] & eff[g] & ~eff_q[g];
    assign lvl_req[g]  = pwr_good &  trig[g] & eff[g] & ~rirr[g];
    assign eoi_hit[g]  = eoi_valid & (vec[g] == eoi_vector);
  end

  // only the lowest matching entry retires
  assign eoi_first = eoi_hit & (~eoi_hit + NUM_IN'(1));

  rr_pick #(.W(NUM_IN), .IW(ENT_W)) u_pick (
    .req (pend_q),
    .oh  (gnt_oh),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  assign take   = accept ? gnt_oh : '0;
  assign pend_d = (pend_q & ~take) | edge_req | lvl_req;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      eff_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= raw_d;
      eff_q  <= eff;
      pend_q <= pend_d;
    end
  end

  assign pend_o   = pend_q;
  assign rirr_set = lvl_req;
  assign rirr_clr = eoi_first;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_IN = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pwr_good,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic              msg_dest_mode,
  output logic [2:0]        msg_deliv,
  output logic              msg_level,
  output logic              msg_trig,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_dest
);

  localparam int ENT_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic                    rst_sync_n;
  route_ent_t [NUM_IN-1:0] ents;
  logic [NUM_IN-1:0]       pend, rirr_set, rirr_clr;
  logic [NUM_IN-1:0]       e_pol, e_mask, e_trig, e_rirr;
  logic [NUM_IN-1:0][7:0]  e_vec;
  logic                    gnt_any;
  logic [ENT_W-1:0]        gnt_idx;
  route_ent_t              cur;

  rr_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  rr_regfile #(.NUM_IN(NUM_IN), .ENT_W(ENT_W)) u_regs (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .pend     (pend),
    .rirr_set (rirr_set),
    .rirr_clr (rirr_clr),
    .ents_o   (ents)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_split
    assign e_pol[g]  = ents[g].pol;
    assign e_mask[g] = ents[g].mask;
    assign e_trig[g] = ents[g].trig;
    assign e_rirr[g] = ents[g].rirr;
    assign e_vec[g]  = ents[g].vec;
  end

  rr_request #(.NUM_IN(NUM_IN), .ENT_W(ENT_W)) u_req (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .pwr_good   (pwr_good),
    .irq_in     (irq_in),
    .pol        (e_pol),
    .mask       (e_mask),
    .trig       (e_trig),
    .rirr       (e_rirr),
    .vec        (e_vec),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .accept     (msg_ready),
    .pend_o     (pend),
    .rirr_set   (rirr_set),
    .rirr_clr   (rirr_clr),
    .gnt_any    (gnt_any),
    .gnt_idx    (gnt_idx)
  );

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (gnt_idx == ENT_W'(i)) cur = ents[i];
    end
  end

  assign msg_valid     = gnt_any;
  assign msg_dest_mode = cur.dmode;
  assign msg_deliv     = cur.deliv;
  assign msg_level     = 1'b1;
  assign msg_trig      = cur.trig;
  assign msg_vector    = cur.vec;
  assign msg_dest      = cur.dest;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
  input logic        clk,
  input logic        rst_ni,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [7:0]  wr_sel,
  input logic [31:0] reg_rdata,
  input logic        pwr_good,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic        msg_level
);

  // R12: an offered message is withdrawn only by acceptance
  p_valid_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R13: every offered message carries the level bit
  p_level_one_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    msg_valid |-> msg_level);

  // R11: nothing new appears while power is low
  p_unpowered_quiet_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pwr_good && !msg_valid) |=> !msg_valid);

  // R1: a select write reads back at offset 0 on the next cycle
  p_sel_readback_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && !reg_addr) |=> (reg_addr || (reg_rdata == {24'h0, $past(wr_sel)})));

endmodule

bind irq_router irq_router_chk u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wr_sel    (reg_wdata[7:0]),
  .reg_rdata (reg_rdata),
  .pwr_good  (pwr_good),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_level (msg_level)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;

  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          pwr_good;
  logic [N-1:0]  irq_in;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          msg_valid, msg_ready, msg_dest_mode, msg_level, msg_trig;
  logic [2:0]    msg_deliv;
  logic [7:0]    msg_vector, msg_dest;

  int n_checks = 0;
  int n_err    = 0;

  logic [3:0]  m_id;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  always #4 clk = ~clk;

  irq_router #(.NUM_IN(N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_good(pwr_good),
    .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest_mode(msg_dest_mode),
    .msg_deliv(msg_deliv), .msg_level(msg_level), .msg_trig(msg_trig),
    .msg_vector(msg_vector), .msg_dest(msg_dest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mpack(input logic dm, input logic [2:0] dl,
      input logic tr, input logic [7:0] v, input logic [7:0] d);
    return {10'h0, dm, dl, 1'b1, tr, v, d};
  endfunction

  function automatic logic [31:0] mact();
    return {10'h0, msg_dest_mode, msg_deliv, msg_level, msg_trig, msg_vector, msg_dest};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] idx);
    if (idx == 8'h00) return {4'h0, m_id, 24'h0};
    if (idx == 8'h01) return 32'h0017_0011;
    if (idx >= 8'h10 && idx <= 8'h3F)
      return idx[0] ? m_hi[(idx - 8'h10) >> 1] : m_lo[(idx - 8'h10) >> 1];
    return 32'h0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [31:0] d);
    wr(1'b0, {24'h0, idx});
    wr(1'b1, d);
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] v);
    wr(1'b0, {24'h0, idx});
    reg_addr = 1'b1;
    #1 v = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  task automatic accept();
    @(negedge clk) msg_ready = 1'b1;
    @(negedge clk) msg_ready = 1'b0;
    #1;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b1; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    pwr_good = 1'b1; irq_in = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
    #2;
    do_reset();

    // R6 / R1 reset state
    #1 chk("R6 select after reset", reg_rdata, 32'h0);
    rdchk("R6 id after reset", 8'h00, 32'h0800_0000);
    rdchk("R2 version", 8'h01, 32'h0017_0011);
    rdchk("R2 arbitration", 8'h02, 32'h0);
    rdchk("R6 entry3 low after reset", 8'h16, 32'h0001_0000);
    rdchk("R6 entry3 high after reset", 8'h17, 32'h0);
    wr(1'b0, 32'h0000_0117); reg_addr = 1'b0;
    #1 chk("R1 select readback", reg_rdata, 32'h17);
    chk("R6 no message after reset", {31'h0, msg_valid}, 32'h0);

    // R2 / R3 writes
    wreg(8'h00, 32'hFF00_0000);
    rdchk("R2 id write", 8'h00, 32'h0F00_0000);
    wreg(8'h01, 32'hFFFF_FFFF);
    rdchk("R2 version ignores write", 8'h01, 32'h0017_0011);
    wreg(8'h02, 32'hFFFF_FFFF);
    rdchk("R2 arbitration ignores write", 8'h02, 32'h0);
    wreg(8'h05, 32'hFFFF_FFFF);
    rdchk("R3 reserved low", 8'h05, 32'h0);
    wreg(8'h40, 32'hFFFF_FFFF);
    rdchk("R3 reserved high", 8'h40, 32'h0);
    rdchk("R3 write did not reach id", 8'h00, 32'h0F00_0000);

    // R4 / R5 layout
    wreg(8'h17, 32'hA5FF_FFFF);
    rdchk("R4 destination field", 8'h17, 32'hA500_0000);
    wreg(8'h16, 32'h0001_FFFF);
    rdchk("R5 status not writable", 8'h16, 32'h0001_EFFF);
    wreg(8'h16, 32'h0000_0B43);

    // R8 edge mode
    @(negedge clk) irq_in[3] = 1'b1;
    cyc(1); #1 chk("R8 not yet valid", {31'h0, msg_valid}, 32'h0);
    cyc(1); #1 chk("R8 valid after two edges", {31'h0, msg_valid}, 32'h1);
    chk("R13 message fields", mact(), mpack(1'b1, 3'd3, 1'b0, 8'h43, 8'hA5));
    rdchk("R5 status while pending", 8'h16, 32'h0000_1B43);
    accept();
    chk("R12 cleared on accept", {31'h0, msg_valid}, 32'h0);
    rdchk("R5 status after accept", 8'h16, 32'h0000_0B43);
    cyc(5); #1 chk("R8 steady input gives one message", {31'h0, msg_valid}, 32'h0);
    @(negedge clk) irq_in[3] = 1'b0;
    cyc(2);
    @(negedge clk) irq_in[3] = 1'b1;
    cyc(2); #1 chk("R8 second edge", {31'h0, msg_valid}, 32'h1);
    accept();

    // R12 priority
    wreg(8'h1E, 32'h0000_0070);
    wreg(8'h22, 32'h0000_0090);
    @(negedge clk) begin irq_in[7] = 1'b1; irq_in[9] = 1'b1; end
    cyc(2); #1 chk("R12 lowest first", {24'h0, msg_vector}, 32'h70);
    cyc(3); #1 chk("R12 held until accepted", {23'h0, msg_valid, msg_vector}, 32'h170);
    accept();
    chk("R12 next pending", {23'h0, msg_valid, msg_vector}, 32'h190);
    accept();
    chk("R12 drained", {31'h0, msg_valid}, 32'h0);

    // R7 mask and polarity
    @(negedge clk) irq_in[11] = 1'b1;
    cyc(4); #1 chk("R7 masked input silent", {31'h0, msg_valid}, 32'h0);
    wreg(8'h28, 32'h0000_20C0);
    cyc(1); #1 chk("R7 active-low entry fires", {23'h0, msg_valid, msg_vector}, 32'h1C0);
    accept();
    @(negedge clk) irq_in[12] = 1'b1;
    cyc(4); #1 chk("R7 active-low deasserted", {31'h0, msg_valid}, 32'h0);

    // R11 power
    @(negedge clk) irq_in[3] = 1'b0;
    cyc(2);
    pwr_good = 1'b0;
    @(negedge clk) irq_in[3] = 1'b1;
    cyc(4); #1 chk("R11 no message unpowered", {31'h0, msg_valid}, 32'h0);
    pwr_good = 1'b1;
    cyc(3); #1 chk("R11 lost edge stays lost", {31'h0, msg_valid}, 32'h0);

    // R9 / R10 level mode
    wreg(8'h18, 32'h0000_8144);
    @(negedge clk) irq_in[4] = 1'b1;
    cyc(2); #1 chk("R9 level message", mact(), mpack(1'b0, 3'd1, 1'b1, 8'h44, 8'h00));
    rdchk("R9 remote irr set", 8'h18, 32'h0000_D144);
    accept();
    rdchk("R9 remote irr held", 8'h18, 32'h0000_C144);
    cyc(4); #1 chk("R9 no repeat while in service", {31'h0, msg_valid}, 32'h0);
    eoi(8'h44);
    chk("R10 not yet reissued", {31'h0, msg_valid}, 32'h0);
    cyc(1); #1 chk("R10 reissued", {23'h0, msg_valid, msg_vector}, 32'h144);
    accept();
    @(negedge clk) irq_in[4] = 1'b0;
    cyc(2);
    eoi(8'h44);
    cyc(3); #1 chk("R10 inactive not reissued", {31'h0, msg_valid}, 32'h0);
    rdchk("R10 remote irr cleared", 8'h18, 32'h0000_8144);
    @(negedge clk) irq_in[4] = 1'b1;
    cyc(2); accept();
    eoi(8'hEE);
    cyc(3); #1 chk("R10 unmatched eoi", {31'h0, msg_valid}, 32'h0);
    rdchk("R10 unmatched keeps irr", 8'h18, 32'h0000_C144);
    wreg(8'h14, 32'h0001_0044);
    eoi(8'h44);
    cyc(3); #1 chk("R10 lowest match only", {31'h0, msg_valid}, 32'h0);
    rdchk("R10 higher entry untouched", 8'h18, 32'h0000_C144);

    // random register traffic against the model (R1..R5)
    pwr_good = 1'b0; irq_in = '0;
    do_reset();
    m_id = 4'h8;
    for (int e = 0; e < N; e++) begin m_lo[e] = 32'h0001_0000; m_hi[e] = 32'h0; end
    void'($urandom(32'd20240611));
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  idx;
      logic [31:0] d;
      idx = 8'($urandom_range(0, 8'h47));
      d   = $urandom;
      case ($urandom_range(0, 2))
        0: begin
          wreg(idx, d);
          if (idx == 8'h00) m_id = d[27:24];
          else if (idx >= 8'h10 && idx <= 8'h3F) begin
            if (idx[0]) m_hi[(idx - 8'h10) >> 1] = d & 32'hFF00_0000;
            else        m_lo[(idx - 8'h10) >> 1] = d & 32'h0001_EFFF;
          end
        end
        1: rdchk("R4 random window read", idx, exp_rd(idx));
        default: begin
          wr(1'b0, {24'h0, idx}); reg_addr = 1'b0;
          #1 chk("R1 random select read", reg_rdata, {24'h0, idx});
        end
      endcase
    end
    summary();
  end

endmodule